// File: doc/BRIEF.md
# Multithreaded Accumulator ALU

This block is the arithmetic and logic slice of a processor that runs eight hardware threads. Each thread owns three 64-bit registers: an accumulator, an X register and a Y register. Each thread also owns one status byte. The eight bytes are packed into a single 64-bit status word, and thread t owns bits 8*t+7 down to 8*t.

On each clock edge where the operation strobe is high, the block takes an operation code, a 64-bit operand and a thread index. It computes the result from the chosen thread's registers and writes that result back to the thread's destination register. On the same edge it rewrites that thread's status byte. The other seven threads are not touched.

A second, independent read port shows the three registers of any thread, and the full status word is always visible. The surrounding pipeline uses these to observe state.

Top module: `mt_acc_alu`

## Requirements
- R1: Add (op_code 0) computes accumulator + operand + carry flag into the accumulator. Carry becomes bit 64 of the 65-bit sum. Overflow is set when the two inputs have the same sign bit and the result's sign bit differs from the old accumulator's.
- R2: Subtract (op_code 1) computes accumulator - operand - (1 - carry flag) into the accumulator. Carry becomes 1 when no borrow occurs. Overflow is set when the input sign bits differ and the result's sign bit differs from the old accumulator's.
- R3: AND, OR and XOR (op_code 2, 3, 4) combine the operand with the register chosen by op_dest (0 or 3 accumulator, 1 X, 2 Y), write the result to that register, and clear carry and overflow.
- R4: Increment and decrement (op_code 9, 10) add or subtract one, with wraparound, on the register chosen by op_dest, and clear carry and overflow.
- R5: Shift-left (op_code 5) and shift-right (op_code 6) act on the accumulator, with the operand as the count, and clear overflow.
  - A count of 64 or more gives zero.
  - Shift-right sets carry from the old bit 0.
  - For shift-left, carry is old bit 64-n for a count n from 1 to 64, and is 0 for a count of 0 or above 64.
- R6: Rotate-left (op_code 7) and rotate-right (op_code 8) rotate the 65-bit value {carry, accumulator} by the operand's low six bits, and clear overflow.
  - For a count of 1, left inserts the old carry at bit 0 and right sets carry from old bit 0.
  - Right inserts the old carry at bit 64 minus the count.
  - A count of 0 leaves value and carry unchanged.
- R7: After every operation, zero is set when the written 64-bit value is 0, and negative equals its bit 63.
- R8: In a status byte, carry is bit 0, zero is bit 1, overflow is bit 6 and negative is bit 7. An operation changes only the active thread's byte, at bits 8*t+7..8*t.
- R9: Bits 2 to 5 of every status byte (interrupt-disable, stack-protect and two spare bits) are never changed by an operation.
- R10: With op_valid low, or with op_code 11 to 15, no register and no status bit changes.
- R11: Reset clears every register of every thread and the whole status word.
- R12: Add, subtract, shifts and rotates always write the accumulator, whatever op_dest holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, sampled on the rising edge |
| op_code | input | 4 | Operation select |
| op_dest | input | 2 | Destination for logical and step operations |
| op_thread | input | 3 | Thread that executes the operation |
| op_operand | input | 64 | Operand, also the shift or rotate count |
| rd_thread | input | 3 | Thread shown on the read port |
| rd_acc | output | 64 | Accumulator of rd_thread |
| rd_x | output | 64 | X register of rd_thread |
| rd_y | output | 64 | Y register of rd_thread |
| status_o | output | 64 | Packed status word of all threads |

## Verification
Each operation is captured on the rising edge where op_valid is high. Its register and status results are then visible on the read port and status_o right after that edge, because no extra pipeline stage follows the register write. The bench changes inputs on a falling edge and checks on the next falling edge, which is half a cycle after the write. It compares the entire status word against a running expectation after every operation, so a change to a byte of the wrong thread shows up at once. Operations that must have no effect are checked the same way: on the next falling edge the registers and status word must be unchanged.

// File: rtl/mtalu_pkg.sv
package mtalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_ACC = 2'd0,
    DST_X   = 2'd1,
    DST_Y   = 2'd2,
    DST_ALT = 2'd3
  } dst_e;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_V = 6;
  localparam int unsigned FLAG_N = 7;
  localparam int unsigned BYTE_W = 8;

  function automatic logic op_known(input logic [3:0] code);
    return code <= 4'd10;
  endfunction

  function automatic logic op_uses_dest(input logic [3:0] code);
    return (code == OP_AND) || (code == OP_OR) || (code == OP_XOR) ||
           (code == OP_INC) || (code == OP_DEC);
  endfunction

endpackage

// File: rtl/mtalu_arith.sv
module mtalu_arith #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          ovf_o
);

  logic [DW-1:0] b_eff;
  logic [DW:0]   sum_w;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    sum_w  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
    res_o  = sum_w[DW-1:0];
    cout_o = sum_w[DW];
    ovf_o  = (a_i[DW-1] == b_eff[DW-1]) && (sum_w[DW-1] != a_i[DW-1]);
  end

endmodule

// File: rtl/mtalu_shift.sv
module mtalu_shift
  import mtalu_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          cin_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);

  localparam int unsigned SW = $clog2(DW);
  localparam int unsigned RW = SW + 1;

  logic          big_cnt;
  logic          cnt_full;
  logic [SW-1:0] n_s;
  logic [RW-1:0] n_r;
  logic [DW:0]   wide_l;
  logic [DW:0]   ring;
  logic [DW:0]   rot_l;
  logic [DW:0]   rot_r;

  always_comb begin
    big_cnt  = |cnt_i[DW-1:SW];
    cnt_full = (cnt_i == DW[DW-1:0]);
    n_s      = cnt_i[SW-1:0];
    n_r      = {1'b0, n_s};
    wide_l   = {1'b0, a_i} << n_s;
    ring     = {cin_i, a_i};
    rot_l    = (ring << n_r) | (ring >> (RW'(DW + 1) - n_r));
    rot_r    = (ring >> n_r) | (ring << (RW'(DW + 1) - n_r));
    res_o    = a_i;
    cout_o   = cin_i;
    unique case (op_i)
      OP_SHL: begin
        if (big_cnt) begin
          res_o  = '0;
          cout_o = cnt_full ? a_i[0] : 1'b0;
        end else begin
          res_o  = wide_l[DW-1:0];
          cout_o = wide_l[DW];
        end
      end
      OP_SHR: begin
        res_o  = big_cnt ? '0 : (a_i >> n_s);
        cout_o = a_i[0];
      end
      OP_ROL: begin
        res_o  = rot_l[DW-1:0];
        cout_o = rot_l[DW];
      end
      OP_ROR: begin
        res_o  = rot_r[DW-1:0];
        cout_o = rot_r[DW];
      end
      default: begin
        res_o  = a_i;
        cout_o = cin_i;
      end
    endcase
  end

endmodule

// File: rtl/mtalu_logic.sv
module mtalu_logic
  import mtalu_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] res_o
);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_INC:  res_o = a_i + {{(DW-1){1'b0}}, 1'b1};
      OP_DEC:  res_o = a_i - {{(DW-1){1'b0}}, 1'b1};
      default: res_o = a_i;
    endcase
  end

endmodule

// File: rtl/mtalu_regs.sv
module mtalu_regs
  import mtalu_pkg::*;
#(
  parameter int unsigned THREADS = 8,
  parameter int unsigned DW      = 64,
  localparam int unsigned TW     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned SWW    = BYTE_W * THREADS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [TW-1:0]  wr_thread,
  input  dst_e           wr_dest,
  input  logic [DW-1:0]  wr_data,
  input  logic [7:0]     wr_flags,
  input  logic [TW-1:0]  src_thread,
  output logic [DW-1:0]  src_acc,
  output logic [DW-1:0]  src_x,
  output logic [DW-1:0]  src_y,
  output logic           src_carry,
  output logic [3:0]     src_rsvd,
  input  logic [TW-1:0]  rd_thread,
  output logic [DW-1:0]  rd_acc,
  output logic [DW-1:0]  rd_x,
  output logic [DW-1:0]  rd_y,
  output logic [SWW-1:0] status_word
);

  logic [DW-1:0]  acc_q [THREADS];
  logic [DW-1:0]  acc_d [THREADS];
  logic [DW-1:0]  x_q   [THREADS];
  logic [DW-1:0]  x_d   [THREADS];
  logic [DW-1:0]  y_q   [THREADS];
  logic [DW-1:0]  y_d   [THREADS];
  logic [SWW-1:0] stat_q;
  logic [SWW-1:0] stat_d;
  logic [7:0]     src_byte;

  always_comb begin
    for (int i = 0; i < THREADS; i++) begin
      acc_d[i] = acc_q[i];
      x_d[i]   = x_q[i];
      y_d[i]   = y_q[i];
    end
    stat_d = stat_q;
    if (wr_en) begin
      unique case (wr_dest)
        DST_X:   x_d[wr_thread]   = wr_data;
        DST_Y:   y_d[wr_thread]   = wr_data;
        default: acc_d[wr_thread] = wr_data;
      endcase
      stat_d[BYTE_W*wr_thread +: BYTE_W] = wr_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < THREADS; i++) begin
        acc_q[i] <= '0;
        x_q[i]   <= '0;
        y_q[i]   <= '0;
      end
      stat_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < THREADS; i++) begin
        acc_q[i] <= acc_d[i];
        x_q[i]   <= x_d[i];
        y_q[i]   <= y_d[i];
      end
      stat_q <= stat_d;
    end
  end

  always_comb begin
    src_acc   = acc_q[src_thread];
    src_x     = x_q[src_thread];
    src_y     = y_q[src_thread];
    src_byte  = stat_q[BYTE_W*src_thread +: BYTE_W];
    src_carry = src_byte[FLAG_C];
    src_rsvd  = src_byte[5:2];
    rd_acc    = acc_q[rd_thread];
    rd_x      = x_q[rd_thread];
    rd_y      = y_q[rd_thread];
  end

  assign status_word = stat_q;

  for (genvar t = 0; t < THREADS; t++) begin : g_byte_chk
    // R8: a byte not addressed by the write keeps its value
    a_r8_other_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_thread == TW'(t))) |=> $stable(stat_q[BYTE_W*t +: BYTE_W]));
    // R9: interrupt-disable, stack-protect and spare bits never move
    a_r9_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(stat_q[BYTE_W*t+2 +: 4]));
  end

endmodule

// File: rtl/mt_acc_alu.sv
module mt_acc_alu
  import mtalu_pkg::*;
#(
  parameter int unsigned THREADS = 8,
  parameter int unsigned DW      = 64,
  localparam int unsigned TW     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned SWW    = BYTE_W * THREADS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [3:0]     op_code,
  input  logic [1:0]     op_dest,
  input  logic [TW-1:0]  op_thread,
  input  logic [DW-1:0]  op_operand,
  input  logic [TW-1:0]  rd_thread,
  output logic [DW-1:0]  rd_acc,
  output logic [DW-1:0]  rd_x,
  output logic [DW-1:0]  rd_y,
  output logic [SWW-1:0] status_o
);

  alu_op_e       op_e;
  dst_e          dst_sel;
  logic [DW-1:0] src_acc, src_x, src_y, src_val;
  logic          src_c;
  logic [3:0]    src_rsvd;
  logic [DW-1:0] ar_res, sh_res, lg_res, result;
  logic          ar_c, ar_v, sh_c;
  logic          new_c, new_v;
  logic [7:0]    new_flags;
  logic          wr_en;

  always_comb begin
    op_e    = alu_op_e'(op_code);
    dst_sel = op_uses_dest(op_code) ? dst_e'(op_dest) : DST_ACC;
    unique case (dst_sel)
      DST_X:   src_val = src_x;
      DST_Y:   src_val = src_y;
      default: src_val = src_acc;
    endcase
    wr_en = op_valid && op_known(op_code);
  end

  mtalu_arith #(.DW(DW)) u_arith (
    .a_i    (src_acc),
    .b_i    (op_operand),
    .cin_i  (src_c),
    .sub_i  (op_e == OP_SUB),
    .res_o  (ar_res),
    .cout_o (ar_c),
    .ovf_o  (ar_v)
  );

  mtalu_shift #(.DW(DW)) u_shift (
    .a_i    (src_acc),
    .cnt_i  (op_operand),
    .cin_i  (src_c),
    .op_i   (op_e),
    .res_o  (sh_res),
    .cout_o (sh_c)
  );

  mtalu_logic #(.DW(DW)) u_logic (
    .a_i   (src_val),
    .b_i   (op_operand),
    .op_i  (op_e),
    .res_o (lg_res)
  );

  always_comb begin
    result = lg_res;
    new_c  = 1'b0;
    new_v  = 1'b0;
    unique case (op_e)
      OP_ADD, OP_SUB: begin
        result = ar_res;
        new_c  = ar_c;
        new_v  = ar_v;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result = sh_res;
        new_c  = sh_c;
      end
      default: begin
        result = lg_res;
      end
    endcase
    new_flags         = '0;
    new_flags[5:2]    = src_rsvd;
    new_flags[FLAG_C] = new_c;
    new_flags[FLAG_Z] = (result == '0);
    new_flags[FLAG_V] = new_v;
    new_flags[FLAG_N] = result[DW-1];
  end

  mtalu_regs #(.THREADS(THREADS), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_thread   (op_thread),
    .wr_dest     (dst_sel),
    .wr_data     (result),
    .wr_flags    (new_flags),
    .src_thread  (op_thread),
    .src_acc     (src_acc),
    .src_x       (src_x),
    .src_y       (src_y),
    .src_carry   (src_c),
    .src_rsvd    (src_rsvd),
    .rd_thread   (rd_thread),
    .rd_acc      (rd_acc),
    .rd_x        (rd_x),
    .rd_y        (rd_y),
    .status_word (status_o)
  );

  // R10: no strobe, no status change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status_o));

  for (genvar t = 0; t < THREADS; t++) begin : g_flag_chk
    // R3: bitwise operations leave carry and overflow clear
    a_r3_logic_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_thread == TW'(t)) && (op_code >= 4'd2) && (op_code <= 4'd4))
      |=> (!status_o[BYTE_W*t+FLAG_C] && !status_o[BYTE_W*t+FLAG_V]));
    // R4: increment/decrement leave carry and overflow clear
    a_r4_step_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_thread == TW'(t)) && ((op_code == 4'd9) || (op_code == 4'd10)))
      |=> (!status_o[BYTE_W*t+FLAG_C] && !status_o[BYTE_W*t+FLAG_V]));
  end

endmodule

// File: tb/tb_mt_acc_alu.sv
module tb_mt_acc_alu;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [1:0]  op_dest;
  logic [2:0]  op_thread;
  logic [63:0] op_operand;
  logic [2:0]  rd_thread;
  logic [63:0] rd_acc, rd_x, rd_y, status_o;

  int n_run;
  int n_fail;
  logic [63:0] exp_sw;

  mt_acc_alu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_dest(op_dest), .op_thread(op_thread), .op_operand(op_operand),
    .rd_thread(rd_thread), .rd_acc(rd_acc), .rd_x(rd_x), .rd_y(rd_y),
    .status_o(status_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] t, input logic [3:0] c, input logic [1:0] d,
                    input logic [63:0] v);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_dest = d; op_thread = t; op_operand = v;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic chk_flags(input string tag, input int t, input logic [7:0] b);
    exp_sw[8*t +: 8] = b;
    check(tag, status_o, exp_sw);
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] t, input int which,
                         input logic [63:0] exp);
    rd_thread = t;
    #1;
    check(tag, (which == 0) ? rd_acc : (which == 1) ? rd_x : rd_y, exp);
  endtask

  task automatic t_reset;
    for (int t = 0; t < 8; t++) begin
      chk_reg("R11 acc", 3'(t), 0, 64'h0);
      chk_reg("R11 x", 3'(t), 1, 64'h0);
      chk_reg("R11 y", 3'(t), 2, 64'h0);
    end
    check("R11 status", status_o, 64'h0);
  endtask

  task automatic t_add;
    op(3'd1, 4'd3, 2'd0, 64'h7FFF_FFFF_FFFF_FFFF);
    chk_flags("R3 load", 1, 8'h00);
    op(3'd1, 4'd0, 2'd0, 64'h1);
    chk_reg("R1 signed overflow value", 3'd1, 0, 64'h8000_0000_0000_0000);
    chk_flags("R1 R7 overflow flags", 1, 8'hC0);
    op(3'd3, 4'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_flags("R7 negative", 3, 8'h80);
    op(3'd3, 4'd0, 2'd0, 64'h1);
    chk_reg("R1 wrap value", 3'd3, 0, 64'h0);
    chk_flags("R1 carry out zero", 3, 8'h03);
    op(3'd3, 4'd0, 2'd0, 64'h5);
    chk_reg("R1 carry in", 3'd3, 0, 64'h6);
    chk_flags("R1 carry cleared", 3, 8'h00);
  endtask

  task automatic t_sub;
    op(3'd4, 4'd1, 2'd0, 64'h0);
    chk_reg("R2 borrow in", 3'd4, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_flags("R2 borrow flags", 4, 8'h80);
    op(3'd4, 4'd0, 2'd0, 64'h1);
    chk_flags("R1 set carry", 4, 8'h03);
    op(3'd4, 4'd1, 2'd0, 64'h3);
    chk_reg("R2 no borrow in", 3'd4, 0, 64'hFFFF_FFFF_FFFF_FFFD);
    chk_flags("R2 borrow out", 4, 8'h80);
    op(3'd5, 4'd3, 2'd0, 64'h8000_0000_0000_0000);
    chk_flags("R3 load", 5, 8'h80);
    op(3'd5, 4'd1, 2'd0, 64'h1);
    chk_reg("R2 overflow value", 3'd5, 0, 64'h7FFF_FFFF_FFFF_FFFE);
    chk_flags("R2 overflow flags", 5, 8'h41);
  endtask

  task automatic t_step;
    op(3'd5, 4'd10, 2'd2, 64'h0);
    chk_reg("R4 dec wrap", 3'd5, 2, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_flags("R4 dec clears cv", 5, 8'h80);
    op(3'd5, 4'd9, 2'd2, 64'h0);
    chk_reg("R4 inc wrap", 3'd5, 2, 64'h0);
    chk_flags("R4 inc zero", 5, 8'h02);
    chk_reg("R4 acc untouched", 3'd5, 0, 64'h7FFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_logic;
    op(3'd6, 4'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    op(3'd6, 4'd0, 2'd0, 64'h1);
    chk_flags("R1 carry before logic", 6, 8'h03);
    op(3'd6, 4'd3, 2'd1, 64'hF0);
    chk_reg("R3 or x", 3'd6, 1, 64'hF0);
    chk_flags("R3 clears carry", 6, 8'h00);
    op(3'd6, 4'd2, 2'd1, 64'h3C);
    chk_reg("R3 and x", 3'd6, 1, 64'h30);
    op(3'd6, 4'd4, 2'd1, 64'h30);
    chk_reg("R3 xor x", 3'd6, 1, 64'h0);
    chk_flags("R3 R7 zero", 6, 8'h02);
    op(3'd6, 4'd3, 2'd2, 64'h8000_0000_0000_0000);
    chk_reg("R3 or y", 3'd6, 2, 64'h8000_0000_0000_0000);
    chk_flags("R7 negative from y", 6, 8'h80);
    chk_reg("R3 acc untouched", 3'd6, 0, 64'h0);
  endtask

  task automatic t_shift;
    op(3'd7, 4'd3, 2'd0, 64'h8000_0000_0000_0001);
    op(3'd7, 4'd6, 2'd0, 64'd1);
    chk_reg("R5 shr value", 3'd7, 0, 64'h4000_0000_0000_0000);
    chk_flags("R5 shr carry", 7, 8'h01);
    op(3'd7, 4'd5, 2'd0, 64'd2);
    chk_reg("R5 shl value", 3'd7, 0, 64'h0);
    chk_flags("R5 shl carry", 7, 8'h03);
    op(3'd7, 4'd3, 2'd0, 64'h5);
    op(3'd7, 4'd5, 2'd0, 64'd64);
    chk_reg("R5 shl 64", 3'd7, 0, 64'h0);
    chk_flags("R5 shl 64 carry", 7, 8'h03);
    op(3'd7, 4'd3, 2'd0, 64'h7);
    op(3'd7, 4'd6, 2'd0, 64'd70);
    chk_reg("R5 shr 70", 3'd7, 0, 64'h0);
    chk_flags("R5 shr 70 carry", 7, 8'h03);
    op(3'd7, 4'd3, 2'd0, 64'h6);
    op(3'd7, 4'd5, 2'd0, 64'd100);
    chk_flags("R5 shl 100", 7, 8'h02);
  endtask

  task automatic t_rotate;
    op(3'd0, 4'd3, 2'd0, 64'h8000_0000_0000_0000);
    op(3'd0, 4'd7, 2'd0, 64'd1);
    chk_reg("R6 rol out", 3'd0, 0, 64'h0);
    chk_flags("R6 rol carry", 0, 8'h03);
    op(3'd0, 4'd7, 2'd0, 64'd1);
    chk_reg("R6 rol in", 3'd0, 0, 64'h1);
    chk_flags("R6 rol carry clr", 0, 8'h00);
    op(3'd0, 4'd8, 2'd0, 64'd1);
    chk_reg("R6 ror out", 3'd0, 0, 64'h0);
    chk_flags("R6 ror carry", 0, 8'h03);
    op(3'd0, 4'd8, 2'd0, 64'd4);
    chk_reg("R6 ror 4", 3'd0, 0, 64'h1000_0000_0000_0000);
    chk_flags("R6 ror 4 flags", 0, 8'h00);
  endtask

  task automatic t_dest;
    op(3'd2, 4'd0, 2'd2, 64'h7);
    chk_reg("R12 acc written", 3'd2, 0, 64'h7);
    chk_reg("R12 y untouched", 3'd2, 2, 64'h0);
    chk_flags("R12 flags", 2, 8'h00);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd0; op_thread = 3'd0; op_operand = 64'h1;
    @(negedge clk);
    chk_reg("R10 no strobe", 3'd0, 0, 64'h1000_0000_0000_0000);
    check("R10 no strobe status", status_o, exp_sw);
    op(3'd0, 4'd12, 2'd0, 64'hFFFF);
    chk_reg("R10 bad code", 3'd0, 0, 64'h1000_0000_0000_0000);
    check("R10 R9 bad code status", status_o, exp_sw);
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; exp_sw = '0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_dest = '0;
    op_thread = '0; op_operand = '0; rd_thread = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_step();
    t_logic();
    t_shift();
    t_rotate();
    t_dest();
    t_ignore();
    check("R8 R9 final status word", status_o, exp_sw);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule